// File: doc/BRIEF.md
# Strap Latch and Test Mode Controller

This block sits in the control logic of a clock synthesizer. When the active-low power-good input first asserts after a power-on reset, it takes a snapshot of the digitised strap inputs. The snapshot holds a three-bit frequency select code, the shared-pair select bit and the test-entry strap. It keeps the latched code for register readback. It also turns the code into a CPU divider select for the synthesizer.

The block also runs a test mode that cannot be left without a reset. There are two ways to enter it:
- **Hardware entry:** the test-entry strap is high at the moment of capture. The frequency select B pin then chooses the test output mode in real time.
- **Software entry:** a control register bit is set at any time after reset. A second register bit then chooses the mode, and the pin is ignored.

After entry, test mode stays active until the next reset, which models a power cycle.

Top module: `strap_test_ctrl`

## Requirements
- R1: While reset is high, and after reset until the straps are captured, `fs_latched`, `itp_sel`, `freq_reserved`, `test_active` and `test_refn` are 0. During the same time `cpu_sel` is 0, the 100 MHz setting.
- R2: Capture happens on the first rising clock edge after reset at which `pwrgd_n` is low. At that edge `{fs_c_in, fs_b_in, fs_a_in}` is stored, and it appears on `fs_latched[2:0]` after that edge.
- R3: After the capture, changes on `pwrgd_n` and on the strap inputs leave `fs_latched` and `itp_sel` unchanged until the next reset.
- R4: `cpu_sel` encodes the CPU divider setting as 0=100, 1=133.33, 2=166.66, 3=200, 4=266.66, 5=333.33, 6=400 MHz. It is decoded from the latched code as follows: 000→4, 001→1, 010→3, 011→2, 100→5, 101→0, 110→6.
- R5: Latched code 111 sets `freq_reserved` to 1 and holds `cpu_sel` at 0. Every other code gives `freq_reserved` = 0.
- R6: `itp_sel` equals the level of `itp_en_in` at the capture edge. A value of 1 selects the CPU debug clock on the shared pair, and 0 selects the eighth SRC pair.
- R7: If `test_sel_hi` is 1 at the capture edge, `test_active` is 1 after that edge. A `test_sel_hi` high at any other edge has no effect.
- R8: In hardware-entered test mode without software entry, `test_refn` equals the level of `fs_b_in` at the previous clock edge. In `test_refn`, 1 means REF/N and 0 means Hi-Z.
- R9: If `sw_test_enter` is 1 at an edge, `test_active` is 1 after it. From then on, `test_refn` follows `sw_test_refn` with a latency of one edge, and `fs_b_in` is ignored.
- R10: If hardware and software entry are both in effect, `sw_test_refn` selects the mode. This includes the case where both happen at the same edge.
- R11: Once `test_active` is 1, it stays 1 until reset, even after `sw_test_enter` returns to 0.
- R12: While `test_active` is 0, `test_refn` is 0 whatever the levels of `sw_test_refn` and `fs_b_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Control clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| pwrgd_n | input | 1 | Active-low power-good; its first low level triggers capture |
| fs_a_in | input | 1 | Frequency select A level |
| fs_b_in | input | 1 | Frequency select B level; also the real-time test mode pin |
| fs_c_in | input | 1 | Frequency select C level |
| test_sel_hi | input | 1 | Compare flag: test-entry strap is at or above the high threshold |
| itp_en_in | input | 1 | Shared-pair function strap |
| sw_test_enter | input | 1 | Register bit that requests test mode entry |
| sw_test_refn | input | 1 | Register bit that selects the mode in software test (1 = REF/N) |
| fs_latched | output | 3 | Latched {C,B,A} code for readback |
| itp_sel | output | 1 | Latched shared-pair select |
| cpu_sel | output | 3 | CPU divider select code |
| freq_reserved | output | 1 | Latched code is the reserved value |
| test_active | output | 1 | Test mode entered (sticky) |
| test_refn | output | 1 | Test output mode: 1 = REF/N, 0 = Hi-Z |

## Verification
Capture with the test-entry strap high and the software entry bit can occur at the same clock edge, and the two entries then compete for the mode source. The bench provokes this with a directed case that lowers `pwrgd_n`, raises `test_sel_hi` and raises `sw_test_enter` together. It drives `fs_b_in` opposite to `sw_test_refn`, and it expects `test_refn` after that edge to equal the register bit. Random trials also raise the software bit at a later edge of a session that is already in hardware test mode, and they check the same priority there.

// File: rtl/strap_pkg.sv
package strap_pkg;

    localparam int FS_W      = 3;
    localparam int CPU_SEL_W = 3;

    typedef logic [FS_W-1:0] fs_code_t;

    typedef enum logic [CPU_SEL_W-1:0] {
        CPU_100 = 3'd0,
        CPU_133 = 3'd1,
        CPU_166 = 3'd2,
        CPU_200 = 3'd3,
        CPU_266 = 3'd4,
        CPU_333 = 3'd5,
        CPU_400 = 3'd6
    } cpu_sel_e;

    // Straps kept after capture; the test-entry strap is consumed as a pulse
    typedef struct packed {
        fs_code_t fs;
        logic     itp;
    } strap_word_t;

    typedef struct packed {
        cpu_sel_e sel;
        logic     reserved;
    } freq_dec_t;

    function automatic freq_dec_t decode_fs(input fs_code_t code);
        freq_dec_t d;
        d.reserved = 1'b0;
        unique case (code)
            3'b000:  d.sel = CPU_266;
            3'b001:  d.sel = CPU_133;
            3'b010:  d.sel = CPU_200;
            3'b011:  d.sel = CPU_166;
            3'b100:  d.sel = CPU_333;
            3'b101:  d.sel = CPU_100;
            3'b110:  d.sel = CPU_400;
            default: begin
                d.sel      = CPU_100;
                d.reserved = 1'b1;
            end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/strap_capture.sv
module strap_capture
    import strap_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        pwrgd_n,
    input  strap_word_t pins,
    input  logic        tsel_pin,
    output strap_word_t held,
    output logic        taken,
    output logic        hw_test_hit
);

    logic take;

    // One capture per reset: only while nothing has been taken yet
    assign take        = !taken && !pwrgd_n;
    assign hw_test_hit = take && tsel_pin;

    always_ff @(posedge clk) begin
        if (rst) begin
            held  <= '0;
            taken <= 1'b0;
        end else if (take) begin
            held  <= pins;
            taken <= 1'b1;
        end
    end

endmodule

// File: rtl/test_mode_ctrl.sv
module test_mode_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic hw_enter,
    input  logic mode_pin,
    input  logic sw_enter,
    input  logic sw_refn,
    output logic active,
    output logic refn
);

    logic hw_q, sw_q, refn_q;
    logic hw_nx, sw_nx, refn_d;

    assign hw_nx = hw_q | hw_enter;
    assign sw_nx = sw_q | sw_enter;

    // Software entry owns the mode source; otherwise the pin does in hardware test
    always_comb begin
        if (sw_nx)      refn_d = sw_refn;
        else if (hw_nx) refn_d = mode_pin;
        else            refn_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hw_q   <= 1'b0;
            sw_q   <= 1'b0;
            refn_q <= 1'b0;
        end else begin
            hw_q   <= hw_nx;
            sw_q   <= sw_nx;
            refn_q <= refn_d;
        end
    end

    assign active = hw_q | sw_q;
    assign refn   = refn_q;

endmodule

// File: rtl/freq_decode.sv
module freq_decode
    import strap_pkg::*;
(
    input  fs_code_t  code,
    input  logic      valid,
    output freq_dec_t dec
);

    always_comb begin
        if (valid) begin
            dec = decode_fs(code);
        end else begin
            dec.sel      = CPU_100;
            dec.reserved = 1'b0;
        end
    end

endmodule

// File: rtl/strap_test_ctrl.sv
module strap_test_ctrl
    import strap_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pwrgd_n,
    input  logic                 fs_a_in,
    input  logic                 fs_b_in,
    input  logic                 fs_c_in,
    input  logic                 test_sel_hi,
    input  logic                 itp_en_in,
    input  logic                 sw_test_enter,
    input  logic                 sw_test_refn,
    output logic [FS_W-1:0]      fs_latched,
    output logic                 itp_sel,
    output logic [CPU_SEL_W-1:0] cpu_sel,
    output logic                 freq_reserved,
    output logic                 test_active,
    output logic                 test_refn
);

    strap_word_t pins, held;
    logic        taken, hw_hit;
    freq_dec_t   dec;

    assign pins.fs  = {fs_c_in, fs_b_in, fs_a_in};
    assign pins.itp = itp_en_in;

    strap_capture u_cap (
        .clk         (clk),
        .rst         (rst),
        .pwrgd_n     (pwrgd_n),
        .pins        (pins),
        .tsel_pin    (test_sel_hi),
        .held        (held),
        .taken       (taken),
        .hw_test_hit (hw_hit)
    );

    test_mode_ctrl u_test (
        .clk      (clk),
        .rst      (rst),
        .hw_enter (hw_hit),
        .mode_pin (fs_b_in),
        .sw_enter (sw_test_enter),
        .sw_refn  (sw_test_refn),
        .active   (test_active),
        .refn     (test_refn)
    );

    freq_decode u_dec (
        .code  (held.fs),
        .valid (taken),
        .dec   (dec)
    );

    assign fs_latched    = held.fs;
    assign itp_sel       = held.itp;
    assign cpu_sel       = dec.sel;
    assign freq_reserved = dec.reserved;

endmodule

// File: rtl/strap_test_ctrl_chk.sv
module strap_test_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       pwrgd_n,
    input logic       fs_a_in,
    input logic       fs_b_in,
    input logic       fs_c_in,
    input logic       itp_en_in,
    input logic       sw_test_enter,
    input logic       sw_test_refn,
    input logic [2:0] fs_latched,
    input logic       itp_sel,
    input logic [2:0] cpu_sel,
    input logic       freq_reserved,
    input logic       test_active,
    input logic       test_refn
);

    logic seen_low;

    always_ff @(posedge clk) begin
        if (rst)           seen_low <= 1'b0;
        else if (!pwrgd_n) seen_low <= 1'b1;
    end

    // R2: first low power-good edge stores the pins
    p_capture_r2: assert property (@(posedge clk) disable iff (rst)
        (!pwrgd_n && !seen_low) |=> (fs_latched == $past({fs_c_in, fs_b_in, fs_a_in})
                                     && itp_sel == $past(itp_en_in)));

    // R3: no re-sampling after capture
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        seen_low |=> ($stable(fs_latched) && $stable(itp_sel)));

    // R5: reserved code pins the divider at 100 MHz
    p_reserved_r5: assert property (@(posedge clk) disable iff (rst)
        freq_reserved |-> (cpu_sel == 3'd0 && fs_latched == 3'b111));

    // R9: software entry activates and takes the register bit as source
    p_sw_src_r9: assert property (@(posedge clk) disable iff (rst)
        sw_test_enter |=> (test_active && test_refn == $past(sw_test_refn)));

    // R11: test mode is sticky
    p_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        test_active |=> test_active);

    // R12: no test mode means no REF/N
    p_idle_refn_r12: assert property (@(posedge clk) disable iff (rst)
        !test_active |-> !test_refn);

endmodule

bind strap_test_ctrl strap_test_ctrl_chk u_chk (.*);

// File: tb/tb_strap_test_ctrl.sv
module tb_strap_test_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwrgd_n = 1'b1;
    logic       fs_a_in = 1'b0, fs_b_in = 1'b0, fs_c_in = 1'b0;
    logic       test_sel_hi = 1'b0, itp_en_in = 1'b0;
    logic       sw_test_enter = 1'b0, sw_test_refn = 1'b0;
    logic [2:0] fs_latched, cpu_sel;
    logic       itp_sel, freq_reserved, test_active, test_refn;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    strap_test_ctrl dut (.*);

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; pwrgd_n = 1'b1; sw_test_enter = 1'b0; sw_test_refn = 1'b0;
        test_sel_hi = 1'b0;
        tick(); tick();
        rst = 1'b0;
    endtask

    task automatic set_fs(input logic [2:0] f);
        {fs_c_in, fs_b_in, fs_a_in} = f;
    endtask

    function automatic logic [2:0] exp_cpu(input logic [2:0] f);
        case (f)
            3'b000: return 3'd4;
            3'b001: return 3'd1;
            3'b010: return 3'd3;
            3'b011: return 3'd2;
            3'b100: return 3'd5;
            3'b101: return 3'd0;
            3'b110: return 3'd6;
            default: return 3'd0;
        endcase
    endfunction

    function automatic logic exp_res(input logic [2:0] f);
        return (f == 3'b111);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_vec++;
            $display("FAIL watchdog got 0 expected 1");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0a17));

        // R1: reset state, then pre-capture state with pins busy
        set_fs(3'b111); itp_en_in = 1'b1; sw_test_refn = 1'b1;
        tick();
        chk("R1 fs in reset", fs_latched, 0);
        chk("R1 cpu in reset", cpu_sel, 0);
        chk("R1 active in reset", test_active, 0);
        do_reset();
        set_fs(3'b111); itp_en_in = 1'b1;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R1 fs pre-capture", fs_latched, 0);
            chk("R1 itp pre-capture", itp_sel, 0);
            chk("R1 cpu pre-capture", cpu_sel, 0);
            chk("R1 reserved pre-capture", freq_reserved, 0);
            chk("R1 refn pre-capture", test_refn, 0);
        end

        // R4 / R5: every code
        for (int c = 0; c < 8; c++) begin
            do_reset();
            set_fs(c[2:0]); pwrgd_n = 1'b0;
            tick();
            chk("R2 fs captured", fs_latched, c);
            chk("R4 cpu decode", cpu_sel, exp_cpu(c[2:0]));
            chk("R5 reserved flag", freq_reserved, exp_res(c[2:0]));
        end

        // R7: late test strap ignored; R12: no REF/N while idle
        do_reset();
        set_fs(3'b010); pwrgd_n = 1'b0; test_sel_hi = 1'b0;
        tick();
        test_sel_hi = 1'b1; sw_test_refn = 1'b1; fs_b_in = 1'b1;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R7 late strap ignored", test_active, 0);
            chk("R12 refn idle", test_refn, 0);
        end

        // R10: capture with test strap and software entry at the same edge
        do_reset();
        set_fs(3'b010); test_sel_hi = 1'b1; pwrgd_n = 1'b0;
        sw_test_enter = 1'b1; sw_test_refn = 1'b0;
        tick();
        chk("R10 same-edge active", test_active, 1);
        chk("R10 same-edge source", test_refn, 0);
        sw_test_enter = 1'b0; fs_b_in = 1'b1; sw_test_refn = 1'b1;
        tick();
        chk("R10 software bit wins", test_refn, 1);
        sw_test_refn = 1'b0;
        tick();
        chk("R10 pin ignored", test_refn, 0);

        // Random trials
        for (int t = 0; t < 150; t++) begin
            logic [2:0] f;
            logic it, ts, b, sw_bit;
            f  = 3'($urandom % 8);
            it = 1'($urandom % 2);
            ts = 1'($urandom % 2);
            do_reset();
            for (int k = 0; k < int'($urandom % 3); k++) begin
                set_fs(3'($urandom)); itp_en_in = 1'($urandom); test_sel_hi = 1'($urandom);
                tick();
            end
            set_fs(f); itp_en_in = it; test_sel_hi = ts; pwrgd_n = 1'b0;
            tick();
            chk("R2 fs captured", fs_latched, f);
            chk("R4 cpu decode", cpu_sel, exp_cpu(f));
            chk("R5 reserved flag", freq_reserved, exp_res(f));
            chk("R6 itp select", itp_sel, it);
            chk("R7 hw entry", test_active, ts);
            chk("R8 first mode", test_refn, ts ? f[1] : 1'b0);
            for (int k = 0; k < 3; k++) begin
                set_fs(3'($urandom)); itp_en_in = 1'($urandom);
                pwrgd_n = 1'($urandom); test_sel_hi = 1'($urandom);
                tick();
                chk("R3 fs held", fs_latched, f);
                chk("R3 itp held", itp_sel, it);
            end
            if (ts) begin
                for (int k = 0; k < 4; k++) begin
                    b = 1'($urandom); fs_b_in = b;
                    tick();
                    chk("R8 pin mode", test_refn, b);
                end
            end
            if ($urandom % 2 == 1) begin
                sw_bit = 1'($urandom);
                sw_test_enter = 1'b1; sw_test_refn = sw_bit; fs_b_in = ~sw_bit;
                tick();
                chk("R9 sw active", test_active, 1);
                chk(ts ? "R10 sw over hw" : "R9 sw source", test_refn, sw_bit);
                sw_test_enter = 1'b0;
                for (int k = 0; k < 3; k++) begin
                    sw_bit = 1'($urandom); sw_test_refn = sw_bit; fs_b_in = 1'($urandom);
                    tick();
                    chk("R11 sticky sw", test_active, 1);
                    chk("R9 sw bit follows", test_refn, sw_bit);
                end
            end else begin
                sw_test_refn = 1'b1; fs_b_in = 1'b1;
                tick();
                chk("R11 sticky hw", test_active, ts);
                if (!ts) chk("R12 refn idle", test_refn, 0);
            end
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule